// File: doc/BRIEF.md
# Row and Column Offset Corrector for Raster Pixel Streams

This block takes a raster pixel stream and removes the offsets that a sensor adds to whole rows and whole columns. The stream carries a valid strobe, a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of each row. First a calibration pass runs over a parameterised number of flat-field frames (100 by default). During that pass the block sums every row, every column and the whole image. A sequential divider then turns those sums into integer means. From the means it derives one signed offset for each row and one for each column, each measured against the global mean.

Once calibration has finished, software may switch the block into correction mode. In that mode each pixel receives its row offset added and its column offset subtracted, and the result is clamped to the pixel range. The output stream has exactly the same form as the input and lags it by one clock. Image size, pixel width and frame count are parameters. The default image is 128 columns by 64 rows of 8-bit pixels.

Top module: `fpn_corrector`

## Requirements
- R1: After a calibration request, summing starts at the next pixel flagged start-of-frame. Pixels that arrive before it are not counted. A frame ends on an end-of-line flag on row index ROWS-1, where rows are counted from 0 at start-of-frame.
- R2: `cal_done` stays low while calibration frames are still arriving and while division runs. It rises only after the NFRAMES-th frame end, once the last offset has been stored.
- R3: The row, column and total accumulators are sized so that NFRAMES frames of full-scale pixels cannot wrap them. During calibration the total sum never decreases.
- R4: Every mean is a floor division. Row mean = row sum / (NFRAMES·COLS). Global mean = total / (NFRAMES·ROWS·COLS). Row offset = global mean − row mean.
- R5: Column mean = column sum / (NFRAMES·ROWS). Column offset = column mean − global mean.
- R6: In correction mode, output pixel = input pixel + row offset − column offset, using the offsets of that pixel's own row and column.
- R7: A corrected value below 0 is output as 0. A corrected value above 2^PIX_W−1 (255 by default) is output as 2^PIX_W−1.
- R8: `out_valid`, `out_sof` and `out_eol` repeat `in_valid`, `in_sof` and `in_eol` one clock later. `out_pix` belongs to the input pixel of that same earlier cycle.
- R9: A `corr_start` pulse is ignored while `cal_done` is low. When `cal_done` is high and the block is idle, a `corr_start` pulse makes `corr_active` go high on the next clock.
- R10: When correction is not active, `out_pix` equals the input pixel of the previous cycle, unchanged.
- R11: A `cal_start` pulse in any mode clears `cal_done` and `corr_active` on the next clock and begins a new calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cal_start | input | 1 | Pulse: clear sums and begin calibration |
| corr_start | input | 1 | Pulse: enter correction mode (only once calibration is done) |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Delayed start-of-frame |
| out_eol | output | 1 | Delayed end-of-line |
| out_pix | output | PIX_W | Corrected pixel, or the bypassed pixel |
| cal_done | output | 1 | Offsets computed and held |
| corr_active | output | 1 | Correction mode engaged |

## Verification
Any fault in the sums, in the divider sequence or in the offset tables stays hidden until the first corrected frame. There it appears at once as wrong pixel values in the rows or columns concerned. A bench can therefore only catch such faults through correction frames, and those frames must use several pixel patterns, including ones at full scale and at zero that force saturation. A fault in the row or column position tracking gives a different sign: the flags still line up, but the offsets are applied to shifted positions, so errors appear at row or frame boundaries. A fault in the mode control appears within a clock of a `corr_start` or `cal_start` pulse.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_DIV  = 2'd2,
    ST_CORR = 2'd3
  } fpn_state_e;

  // Pixel plus row offset minus column offset, in a width that cannot overflow.
  function automatic logic signed [17:0] fpn_correct(input logic [15:0] pix,
                                                     input logic signed [15:0] ro,
                                                     input logic signed [15:0] co);
    return $signed({2'b00, pix}) + 18'(ro) - 18'(co);
  endfunction

  // Clamp a signed value to the range 0 .. 2^pw-1.
  function automatic logic [15:0] fpn_saturate(input logic signed [17:0] v,
                                               input int unsigned pw);
    logic signed [17:0] mx;
    mx = 18'((1 << pw) - 1);
    if (v < 0) return 16'd0;
    else if (v > mx) return mx[15:0];
    else return v[15:0];
  endfunction

endpackage

// File: rtl/fpn_position.sv
module fpn_position #(
  parameter int ROWS = 64,
  parameter int COLS = 128,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          sof,
  input  logic          eol,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col,
  output logic          frame_end
);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  assign cur_row   = sof ? '0 : row_q;
  assign cur_col   = sof ? '0 : col_q;
  assign frame_end = valid && eol && (cur_row == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (valid) begin
      if (eol) begin
        col_q <= '0;
        row_q <= (cur_row == RW'(ROWS - 1)) ? '0 : cur_row + RW'(1);
      end else begin
        col_q <= (cur_col == CW'(COLS - 1)) ? '0 : cur_col + CW'(1);
        row_q <= cur_row;
      end
    end
  end

  // R1: an end-of-line always returns the column position to zero
  a_r1_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    valid && eol |=> col_q == '0);

  // R1: a frame end returns the row position to zero
  a_r1_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> row_q == '0);

endmodule

// File: rtl/fpn_accum.sv
module fpn_accum #(
  parameter int ROWS  = 64,
  parameter int COLS  = 128,
  parameter int PIX_W = 8,
  parameter int SUM_W = 22,
  parameter int TOT_W = 28,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             acc_en,
  input  logic [RW-1:0]    row_idx,
  input  logic [CW-1:0]    col_idx,
  input  logic [PIX_W-1:0] pix,
  output logic [SUM_W-1:0] row_sum [ROWS],
  output logic [SUM_W-1:0] col_sum [COLS],
  output logic [TOT_W-1:0] total
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int r = 0; r < ROWS; r++) row_sum[r] <= '0;
      for (int c = 0; c < COLS; c++) col_sum[c] <= '0;
      total <= '0;
    end else if (acc_en) begin
      row_sum[row_idx] <= row_sum[row_idx] + SUM_W'(pix);
      col_sum[col_idx] <= col_sum[col_idx] + SUM_W'(pix);
      total            <= total + TOT_W'(pix);
    end
  end

  // R3: the total never wraps while pixels are being summed
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !clear |=> total >= $past(total));

endmodule

// File: rtl/fpn_divider.sv
module fpn_divider #(
  parameter int W  = 28,
  parameter int QW = 8,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient
);

  logic [W-1:0]    num_q, rem_q, dvs_q;
  logic [CNTW-1:0] cnt_q;
  logic [W:0]      shifted;
  logic            ge;

  assign shifted = {rem_q, num_q[W-1]};
  assign ge      = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q    <= '0;
      rem_q    <= '0;
      dvs_q    <= '0;
      cnt_q    <= '0;
      quotient <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        num_q    <= dividend;
        dvs_q    <= divisor;
        rem_q    <= '0;
        quotient <= '0;
        cnt_q    <= CNTW'(W);
        busy     <= 1'b1;
      end else if (busy) begin
        rem_q    <= ge ? shifted[W-1:0] - dvs_q : shifted[W-1:0];
        quotient <= {quotient[QW-2:0], ge};
        num_q    <= {num_q[W-2:0], 1'b0};
        cnt_q    <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: restoring division keeps the partial remainder below the divisor
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_q < dvs_q);

  // R4: a start request always engages the divider on the next cycle
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/fpn_corrector.sv
module fpn_corrector #(
  parameter int COLS    = 128,
  parameter int ROWS    = 64,
  parameter int PIX_W   = 8,
  parameter int NFRAMES = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic             corr_start,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [PIX_W-1:0] out_pix,
  output logic             cal_done,
  output logic             corr_active
);
  import fpn_pkg::*;

  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int MAXD    = (ROWS > COLS) ? ROWS : COLS;
  localparam int SUM_W   = $clog2(NFRAMES * MAXD * PIX_MAX + 1);
  localparam int TOT_W   = $clog2(NFRAMES * ROWS * COLS * PIX_MAX + 1);
  localparam int RW      = $clog2(ROWS);
  localparam int CW      = $clog2(COLS);
  localparam int IW      = $clog2(ROWS + COLS + 1);
  localparam int FW      = $clog2(NFRAMES + 1);
  localparam int OFF_W   = PIX_W + 2;
  localparam int LAST    = ROWS + COLS;
  localparam logic [TOT_W-1:0] DV_G = TOT_W'(NFRAMES * ROWS * COLS);
  localparam logic [TOT_W-1:0] DV_R = TOT_W'(NFRAMES * COLS);
  localparam logic [TOT_W-1:0] DV_C = TOT_W'(NFRAMES * ROWS);

  fpn_state_e state;
  logic [FW-1:0]    fcnt;
  logic             in_frame;
  logic [IW-1:0]    seq_idx;
  logic             kick;
  logic [PIX_W-1:0] gmean;

  // Named events shared by the logic and the assertions
  logic [RW-1:0]    pos_row;
  logic [CW-1:0]    pos_col;
  logic             frame_end;
  logic             acc_en;
  logic             div_busy, div_done;
  logic [PIX_W-1:0] div_q;
  logic [TOT_W-1:0] dvd_sel, dvs_sel;
  logic [SUM_W-1:0] row_sum [ROWS];
  logic [SUM_W-1:0] col_sum [COLS];
  logic [TOT_W-1:0] total;
  logic [IW-1:0]    idx_m1;
  logic [RW-1:0]    row_sel;
  logic [CW-1:0]    col_sel;
  logic signed [OFF_W-1:0] row_off [ROWS];
  logic signed [OFF_W-1:0] col_off [COLS];
  logic signed [OFF_W-1:0] row_off_rd, col_off_rd;
  logic signed [17:0]      corr_sum;

  assign corr_active = (state == ST_CORR);
  assign acc_en      = (state == ST_CAL) && in_valid && (in_sof || in_frame);

  fpn_position #(.ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .sof(in_sof), .eol(in_eol),
    .cur_row(pos_row), .cur_col(pos_col), .frame_end(frame_end)
  );

  fpn_accum #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .SUM_W(SUM_W), .TOT_W(TOT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(cal_start), .acc_en(acc_en),
    .row_idx(pos_row), .col_idx(pos_col), .pix(in_pix),
    .row_sum(row_sum), .col_sum(col_sum), .total(total)
  );

  // Division sequence: index 0 is the global mean, then rows, then columns
  always_comb begin
    idx_m1  = seq_idx - IW'(1);
    row_sel = RW'(idx_m1);
    col_sel = CW'(idx_m1 - IW'(ROWS));
    if (seq_idx == '0) begin
      dvd_sel = total;
      dvs_sel = DV_G;
    end else if (seq_idx <= IW'(ROWS)) begin
      dvd_sel = TOT_W'(row_sum[row_sel]);
      dvs_sel = DV_R;
    end else begin
      dvd_sel = TOT_W'(col_sum[col_sel]);
      dvs_sel = DV_C;
    end
  end

  fpn_divider #(.W(TOT_W), .QW(PIX_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(kick), .dividend(dvd_sel), .divisor(dvs_sel),
    .busy(div_busy), .done(div_done), .quotient(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cal_done <= 1'b0;
      fcnt     <= '0;
      in_frame <= 1'b0;
      seq_idx  <= '0;
      kick     <= 1'b0;
      gmean    <= '0;
    end else begin
      kick <= 1'b0;
      if (cal_start) begin
        state    <= ST_CAL;
        cal_done <= 1'b0;
        fcnt     <= '0;
        in_frame <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (corr_start && cal_done) state <= ST_CORR;
          ST_CAL: begin
            if (in_valid && in_sof) in_frame <= 1'b1;
            if (acc_en && frame_end) begin
              fcnt <= fcnt + FW'(1);
              if (fcnt == FW'(NFRAMES - 1)) begin
                state    <= ST_DIV;
                in_frame <= 1'b0;
                seq_idx  <= '0;
                kick     <= 1'b1;
              end
            end
          end
          ST_DIV: begin
            if (div_done) begin
              if (seq_idx == '0) gmean <= div_q;
              if (seq_idx == IW'(LAST)) begin
                state    <= ST_IDLE;
                cal_done <= 1'b1;
              end else begin
                seq_idx <= seq_idx + IW'(1);
                kick    <= 1'b1;
              end
            end
          end
          ST_CORR: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Offset tables, written once per divider result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) row_off[r] <= '0;
      for (int c = 0; c < COLS; c++) col_off[c] <= '0;
    end else if (state == ST_DIV && div_done && seq_idx != '0) begin
      if (seq_idx <= IW'(ROWS))
        row_off[row_sel] <= $signed({2'b00, gmean}) - $signed({2'b00, div_q});
      else
        col_off[col_sel] <= $signed({2'b00, div_q}) - $signed({2'b00, gmean});
    end
  end

  // Correction stage: one register between input and output
  assign row_off_rd = row_off[pos_row];
  assign col_off_rd = col_off[pos_col];
  assign corr_sum   = fpn_correct(16'(in_pix), 16'(row_off_rd), 16'(col_off_rd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid && in_sof;
      out_eol   <= in_valid && in_eol;
      out_pix   <= corr_active ? PIX_W'(fpn_saturate(corr_sum, PIX_W)) : in_pix;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_sof_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |=> out_sof);
  a_r9_corr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    corr_active |-> cal_done);
  a_r2_done_after_div: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(div_done));
  a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !corr_active |=> out_pix == $past(in_pix));
  a_r1_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FW'(NFRAMES));
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_done && !corr_active);

endmodule

// File: tb/tb_fpn_corrector.sv
module tb_fpn_corrector;
  localparam int COLS = 8;
  localparam int ROWS = 4;
  localparam int NFR  = 3;
  localparam int PW   = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cal_start, corr_start, in_valid, in_sof, in_eol;
  logic [PW-1:0] in_pix;
  logic out_valid, out_sof, out_eol, cal_done, corr_active;
  logic [PW-1:0] out_pix;

  fpn_corrector #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PW), .NFRAMES(NFR)) dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .corr_start(corr_start),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix),
    .cal_done(cal_done), .corr_active(corr_active)
  );

  typedef struct { int pix; bit sof; bit eol; string tag; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  int rs[ROWS], cs[COLS], tot;
  int ro[ROWS], co[COLS];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic int pix_of(input int kind, input int f, input int r, input int c);
    case (kind)
      0: return 100 + 6 * r - 5 * c + ((f + r + c) % 3);
      1: return ((r + c) % 2) ? 255 : 0;
      default: return (r * 37 + c * 11 + f * 3) % 256;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    end
  endtask

  task automatic send(input int p, input bit s, input bit e, input bit corr,
                      input int r, input int c, input string tag);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1; in_sof = s; in_eol = e; in_pix = PW'(p);
    x.pix = corr ? clampv(p + ro[r] - co[c]) : p;
    x.sof = s; x.eol = e; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic frame(input int kind, input int f, input bit corr, input bit accum,
                       input string tag);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int p;
        p = pix_of(kind, f, r, c);
        if (accum) begin rs[r] += p; cs[c] += p; tot += p; end
        send(p, (r == 0 && c == 0), (c == COLS - 1), corr, r, c, tag);
        if ((r * COLS + c) % 5 == 4) idle(1);
      end
    idle(2);
  endtask

  task automatic pulse_cal();
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
  endtask

  task automatic pulse_corr();
    @(negedge clk); corr_start = 1'b1;
    @(negedge clk); corr_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected output", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(out_pix) == e.pix, e.tag, int'(out_pix), e.pix);
        check(out_sof == e.sof, "R8 sof", int'(out_sof), int'(e.sof));
        check(out_eol == e.eol, "R8 eol", int'(out_eol), int'(e.eol));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=expired expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cal_start = 1'b0; corr_start = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_pix = '0;
    tot = 0;
    for (int i = 0; i < ROWS; i++) rs[i] = 0;
    for (int i = 0; i < COLS; i++) cs[i] = 0;
    for (int i = 0; i < ROWS; i++) ro[i] = 0;
    for (int i = 0; i < COLS; i++) co[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
    check(cal_done == 1'b0, "R2 reset cal_done", int'(cal_done), 0);
    check(corr_active == 1'b0, "R9 reset corr_active", int'(corr_active), 0);

    // R9: a start request before calibration is ignored
    pulse_corr();
    check(corr_active == 1'b0, "R9 start ignored", int'(corr_active), 0);
    // R10: the uncorrected stream passes through unchanged
    frame(2, 1, 1'b0, 1'b0, "R10 bypass");

    pulse_cal();
    // R1: pixels before the first start-of-frame must not be summed
    for (int i = 0; i < 3; i++) send(255, 1'b0, 1'b0, 1'b0, 0, 0, "R10 bypass");
    idle(2);
    for (int f = 0; f < NFR; f++) begin
      frame(0, f, 1'b0, 1'b1, "R10 bypass");
      if (f == NFR - 2) check(cal_done == 1'b0, "R2 early done", int'(cal_done), 0);
    end
    check(cal_done == 1'b0, "R2 done during division", int'(cal_done), 0);
    pulse_corr();
    check(corr_active == 1'b0, "R9 start during division", int'(corr_active), 0);

    for (int i = 0; i < 2000 && cal_done !== 1'b1; i++) @(negedge clk);
    check(cal_done == 1'b1, "R2 done raised", int'(cal_done), 1);

    // Expected offsets, R4 and R5
    begin
      int g;
      g = tot / (NFR * ROWS * COLS);
      for (int r = 0; r < ROWS; r++) ro[r] = g - rs[r] / (NFR * COLS);
      for (int c = 0; c < COLS; c++) co[c] = cs[c] / (NFR * ROWS) - g;
    end

    pulse_corr();
    check(corr_active == 1'b1, "R9 correction engaged", int'(corr_active), 1);
    frame(0, 1, 1'b1, 1'b0, "R1 R4 R5 R6 flat");
    frame(1, 0, 1'b1, 1'b0, "R7 saturate");
    frame(2, 2, 1'b1, 1'b0, "R6 ramp");

    // R11: recalibration drops correction and the done flag
    pulse_cal();
    check(corr_active == 1'b0, "R11 corr cleared", int'(corr_active), 0);
    check(cal_done == 1'b0, "R11 done cleared", int'(cal_done), 0);
    frame(2, 0, 1'b0, 1'b0, "R11 bypass after restart");
    idle(3);
    check(sb.size() == 0, "R8 outputs missing", sb.size(), 0);
    finish_run();
  end

endmodule